// File: doc/BRIEF.md
# SPI Target Request Capture Engine

This block is the receive front end of a host-command link in which the block acts as an SPI target, running SPI mode 0 (clock idles low, data sampled on the rising edge, changed on the falling edge). The SPI pins are brought into the system clock domain and shifted into bytes. The bytes are packed into 32-bit words and stored in a receive FIFO, and the local processor reads that FIFO through a word port. While the host clocks a request in, the block answers on MISO with a one-byte status code taken from its five-state engine. From this code the host can tell whether the target is switched off, idle, receiving, busy or holding bad data.

A 16-bit request length sits at a programmable byte offset inside the request header, and the block captures it as the bytes stream past. It sets a valid-length flag once the byte count of the transaction reaches a programmed base count plus that length. Chip select behaves as follows:

- Asserting chip select marks the engine busy.
- Releasing chip select raises an end-of-transaction flag and returns the engine to idle.
- Releasing chip select can also flush the FIFO, if that option is enabled.

Both flags are write-one-to-clear, and each can be masked from the combined interrupt. The controller can load any legal state at any time through a state-select input.

Top module: `spi_rqc_top`

## Requirements
- R1: After reset the state output reads 0 (disabled), both flags are clear, the interrupt is low, MISO is low and the FIFO level is 0.
- R2: While chip select is low, each byte shifted out on MISO, most significant bit first, is the code of the current state: 0 gives 0xEC, 1 (ready) gives 0xF8, 2 (receiving) gives 0xF9, 3 (busy) gives 0xFA and 4 (bad data) gives 0xFB. A state loaded during a byte takes effect from the next byte boundary. The first byte of a transaction carries the busy code 0xFA.
- R3: A falling edge on chip select moves the state to busy (3), unless the state is disabled (0), in which case the state is unchanged.
- R4: A pulse on state_we loads state_wdata into the state when the value is 0 to 4. Values 5 to 7 are ignored.
- R5: The length field is read little-endian: its low byte is request byte cfg_len_off and its high byte is byte cfg_len_off+1, counting from 0 at the falling edge of chip select. Once that field is complete and the number of bytes received reaches cfg_base_cnt plus the field, status bit 0 sets. It sets at most once per transaction.
- R6: A rising edge on chip select sets status bit 1 and moves the state to ready (1), unless the state is disabled.
- R7: A pulse on sts_clr_we clears each status bit whose sts_clr bit is 1 and leaves the other bits unchanged.
- R8: irq is high exactly while some status bit is set whose irq_mask bit is 0. A mask bit of 1 suppresses its source.
- R9: The bytes of a transaction are packed into 32-bit words with the first byte in bits 7:0. An incomplete word is discarded at the next falling edge of chip select. rx_valid and rx_pop take effect only while cpu_rx_en is high, and rx_data shows the oldest word.
- R10: With cfg_hold_full set, a full FIFO keeps its contents and drops any further words.
- R11: With cfg_hold_full clear, a word arriving at a full FIFO replaces the oldest word.
- R12: With cfg_auto_flush set, a rising edge on chip select empties the FIFO.
- R13: Bytes that complete while cpu_rx_en is high are not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI clock from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_miso | output | 1 | Status byte stream to the host |
| cfg_base_cnt | input | 16 | Base byte count added to the captured length |
| cfg_len_off | input | 16 | Byte offset of the length field in the header |
| cfg_auto_flush | input | 1 | Empty the FIFO when chip select rises |
| cfg_hold_full | input | 1 | 1: drop new words when full; 0: overwrite the oldest |
| irq_mask | input | 2 | Interrupt masks, 1 masks (bit 0 valid-length, bit 1 end) |
| state_we | input | 1 | Load state_wdata into the state |
| state_wdata | input | 3 | State to load |
| sts_clr_we | input | 1 | Apply the write-one-to-clear pattern |
| sts_clr | input | 2 | Status bits to clear |
| cpu_rx_en | input | 1 | Processor access to the FIFO; blocks SPI-side storage |
| rx_pop | input | 1 | Remove the oldest word |
| rx_data | output | 32 | Oldest word in the FIFO |
| rx_valid | output | 1 | FIFO not empty and access enabled |
| rx_level | output | 4 | Number of words stored |
| sts | output | 2 | Status flags: bit 0 valid-length, bit 1 end of transaction |
| state_o | output | 3 | Current engine state |
| irq | output | 1 | Combined unmasked interrupt |

## Verification
The length capture is tried with a header whose length field sits at offset 2, with a base count of 8. The flag is sampled after byte 12 and again after byte 13, which tells a compare against base plus length apart from one that is off by a byte or uses the wrong byte order.

The FIFO is filled with 40 incrementing bytes twice, once with hold-full set and once with it clear. The first word read back tells the drop-new policy from the overwrite-oldest policy.

Further transactions are run under three conditions:
- in the disabled state, to show that chip select edges leave the state and the flags alone;
- with processor access enabled, to show that no bytes are stored;
- with state writes between bytes, to show each status code reaching MISO at the next byte boundary.

// File: rtl/spi_rqc_pkg.sv
package spi_rqc_pkg;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_READY = 3'd1,
    ST_RECV  = 3'd2,
    ST_BUSY  = 3'd3,
    ST_BAD   = 3'd4
  } eng_state_e;

  localparam logic [2:0] ST_LAST = 3'd4;

  function automatic logic [7:0] status_code(input eng_state_e st);
    case (st)
      ST_READY: status_code = 8'hF8;
      ST_RECV:  status_code = 8'hF9;
      ST_BUSY:  status_code = 8'hFA;
      ST_BAD:   status_code = 8'hFB;
      default:  status_code = 8'hEC;
    endcase
  endfunction

endpackage

// File: rtl/spi_rqc_phy.sv
// Pin synchronizers, mode-0 byte shifter in, status shifter out.
module spi_rqc_phy (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk_i,
  input  logic       mosi_i,
  input  logic       cs_n_i,
  input  logic [7:0] tx_byte_i,
  output logic       miso_o,
  output logic       byte_vld_o,
  output logic [7:0] byte_o,
  output logic       cs_fall_o,
  output logic       cs_rise_o
);
  localparam int NL = 3;          // 0 mosi, 1 sclk, 2 cs_n
  localparam int L_MOSI = 0;
  localparam int L_SCLK = 1;
  localparam int L_CS   = 2;

  logic [NL-1:0] raw;
  logic [NL-1:0] s2;
  logic [NL-1:1] s3;              // edge stage only for clock and select

  assign raw = {cs_n_i, sclk_i, mosi_i};

  for (genvar g = 0; g < NL; g++) begin : g_sync
    localparam logic RV = (g == L_CS);
    logic a_q, b_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_q <= RV;
        b_q <= RV;
      end else begin
        a_q <= raw[g];
        b_q <= a_q;
      end
    end
    assign s2[g] = b_q;
    if (g != L_MOSI) begin : g_edge
      logic c_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= RV;
        else        c_q <= b_q;
      end
      assign s3[g] = c_q;
    end
  end

  logic cs_act, sclk_rise, sclk_fall;
  assign cs_act    = ~s2[L_CS];
  assign cs_fall_o = s3[L_CS] & ~s2[L_CS];
  assign cs_rise_o = ~s3[L_CS] & s2[L_CS];
  assign sclk_rise = cs_act & s2[L_SCLK] & ~s3[L_SCLK];
  assign sclk_fall = cs_act & ~s2[L_SCLK] & s3[L_SCLK];

  logic [2:0] bit_q, bit_d;
  logic [7:0] rx_q, rx_d, tx_q, tx_d, byte_q, byte_d;
  logic       vld_q, vld_d;

  always_comb begin
    bit_d  = bit_q;
    rx_d   = rx_q;
    tx_d   = tx_q;
    byte_d = byte_q;
    vld_d  = 1'b0;
    if (cs_fall_o) begin
      bit_d = '0;
      tx_d  = tx_byte_i;
    end else if (sclk_rise) begin
      rx_d  = {rx_q[6:0], s2[L_MOSI]};
      bit_d = bit_q + 3'd1;
      if (bit_q == 3'd7) begin
        vld_d  = 1'b1;
        byte_d = {rx_q[6:0], s2[L_MOSI]};
      end
    end else if (sclk_fall) begin
      tx_d = (bit_q == 3'd0) ? tx_byte_i : {tx_q[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      byte_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      bit_q  <= bit_d;
      rx_q   <= rx_d;
      tx_q   <= tx_d;
      byte_q <= byte_d;
      vld_q  <= vld_d;
    end
  end

  assign miso_o     = cs_act & tx_q[7];
  assign byte_vld_o = vld_q;
  assign byte_o     = byte_q;
endmodule

// File: rtl/spi_rqc_lencap.sv
// Byte counter, length field capture and target compare.
module spi_rqc_lencap #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          byte_vld_i,
  input  logic [7:0]    byte_i,
  input  logic [CW-1:0] base_i,
  input  logic [CW-1:0] off_i,
  output logic          hit_o
);
  localparam int LW = 16;
  localparam int TW = CW + 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [LW-1:0] len_q, len_d;
  logic          have_q, have_d, fired_q, fired_d, hit_q, hit_d;
  logic          at_lo, at_hi;
  logic [TW-1:0] target;

  always_comb begin
    at_lo   = (cnt_q == off_i);
    at_hi   = (cnt_q == off_i + 1'b1);
    len_d   = len_q;
    have_d  = have_q;
    cnt_d   = cnt_q;
    fired_d = fired_q;
    hit_d   = 1'b0;
    if (byte_vld_i) begin
      if (at_lo) len_d[7:0]  = byte_i;
      if (at_hi) len_d[15:8] = byte_i;
      have_d = have_q | at_hi;
      cnt_d  = cnt_q + 1'b1;
    end
    target = TW'(base_i) + TW'(len_d);
    if (byte_vld_i && !fired_q && have_d && (TW'(cnt_d) >= target)) begin
      hit_d   = 1'b1;
      fired_d = 1'b1;
    end
    if (start_i) begin
      cnt_d   = '0;
      len_d   = '0;
      have_d  = 1'b0;
      fired_d = 1'b0;
      hit_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      len_q   <= '0;
      have_q  <= 1'b0;
      fired_q <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      len_q   <= len_d;
      have_q  <= have_d;
      fired_q <= fired_d;
      hit_q   <= hit_d;
    end
  end

  assign hit_o = hit_q;
endmodule

// File: rtl/spi_rqc_rxfifo.sv
// Little-endian word packer and receive FIFO with a selectable full policy.
module spi_rqc_rxfifo #(
  parameter  int DEPTH = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        flush_i,
  input  logic        byte_vld_i,
  input  logic [7:0]  byte_i,
  input  logic        hold_full_i,
  input  logic        cpu_en_i,
  input  logic        pop_i,
  output logic [31:0] rd_data_o,
  output logic        rd_vld_o,
  output logic [AW:0] level_o
);
  localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    ptr_inc = (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [31:0]      mem [DEPTH];
  logic [2:0][7:0]  pk_q, pk_d;
  logic [1:0]       idx_q, idx_d;
  logic [AW-1:0]    wp_q, wp_d, rp_q, rp_d;
  logic [AW:0]      cnt_q, cnt_d;
  logic             byte_acc, push_req, full, pop_eff, push_eff, drop_old;

  always_comb begin
    byte_acc = byte_vld_i & ~cpu_en_i;
    push_req = byte_acc & (idx_q == 2'd3);
    full     = (cnt_q == FULL_LVL);
    pop_eff  = pop_i & cpu_en_i & (cnt_q != '0);
    push_eff = push_req & (~full | ~hold_full_i | pop_eff) & ~flush_i;
    drop_old = push_eff & full & ~pop_eff;
    pk_d  = pk_q;
    idx_d = idx_q;
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush_i) begin
      idx_d = '0;
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (start_i) begin
        idx_d = '0;
      end else if (byte_acc) begin
        if (idx_q != 2'd3) pk_d[idx_q] = byte_i;
        idx_d = idx_q + 2'd1;
      end
      if (push_eff)           wp_d = ptr_inc(wp_q);
      if (pop_eff || drop_old) rp_d = ptr_inc(rp_q);
      cnt_d = cnt_q + (AW+1)'(push_eff & ~drop_old) - (AW+1)'(pop_eff);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pk_q  <= '0;
      idx_q <= '0;
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      pk_q  <= pk_d;
      idx_q <= idx_d;
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_eff) mem[wp_q] <= {byte_i, pk_q[2], pk_q[1], pk_q[0]};
  end

  assign rd_data_o = mem[rp_q];
  assign rd_vld_o  = cpu_en_i & (cnt_q != '0);
  assign level_o   = cnt_q;
endmodule

// File: rtl/spi_rqc_top.sv
module spi_rqc_top
  import spi_rqc_pkg::*;
#(
  parameter  int DEPTH = 8,
  parameter  int CW    = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_sclk,
  input  logic          spi_mosi,
  input  logic          spi_cs_n,
  output logic          spi_miso,
  input  logic [CW-1:0] cfg_base_cnt,
  input  logic [CW-1:0] cfg_len_off,
  input  logic          cfg_auto_flush,
  input  logic          cfg_hold_full,
  input  logic [1:0]    irq_mask,
  input  logic          state_we,
  input  logic [2:0]    state_wdata,
  input  logic          sts_clr_we,
  input  logic [1:0]    sts_clr,
  input  logic          cpu_rx_en,
  input  logic          rx_pop,
  output logic [31:0]   rx_data,
  output logic          rx_valid,
  output logic [AW:0]   rx_level,
  output logic [1:0]    sts,
  output logic [2:0]    state_o,
  output logic          irq
);
  // reset: asserted asynchronously, released through two flops
  logic [1:0] rs_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  logic       cs_fall, cs_rise, byte_vld, hit;
  logic [7:0] byte_d, tx_byte;
  eng_state_e state_q, state_d;
  logic [1:0] sts_q, sts_d;

  spi_rqc_phy u_phy (
    .clk(clk), .rst_n(rst_s), .sclk_i(spi_sclk), .mosi_i(spi_mosi),
    .cs_n_i(spi_cs_n), .tx_byte_i(tx_byte), .miso_o(spi_miso),
    .byte_vld_o(byte_vld), .byte_o(byte_d), .cs_fall_o(cs_fall),
    .cs_rise_o(cs_rise)
  );

  spi_rqc_lencap #(.CW(CW)) u_len (
    .clk(clk), .rst_n(rst_s), .start_i(cs_fall), .byte_vld_i(byte_vld),
    .byte_i(byte_d), .base_i(cfg_base_cnt), .off_i(cfg_len_off), .hit_o(hit)
  );

  spi_rqc_rxfifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_s), .start_i(cs_fall),
    .flush_i(cs_rise & cfg_auto_flush), .byte_vld_i(byte_vld),
    .byte_i(byte_d), .hold_full_i(cfg_hold_full), .cpu_en_i(cpu_rx_en),
    .pop_i(rx_pop), .rd_data_o(rx_data), .rd_vld_o(rx_valid),
    .level_o(rx_level)
  );

  logic live;
  assign live = (state_q != ST_OFF);

  always_comb begin
    state_d = state_q;
    if (cs_fall && live)                   state_d = ST_BUSY;
    else if (cs_rise && live)              state_d = ST_READY;
    else if (state_we && state_wdata <= ST_LAST) state_d = eng_state_e'(state_wdata);
    sts_d = sts_q & ~(sts_clr_we ? sts_clr : 2'b00);
    if (hit && live)     sts_d[0] = 1'b1;
    if (cs_rise && live) sts_d[1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= ST_OFF;
      sts_q   <= '0;
    end else begin
      state_q <= state_d;
      sts_q   <= sts_d;
    end
  end

  assign tx_byte = status_code(state_d);
  assign sts     = sts_q;
  assign state_o = state_q;
  assign irq     = |(sts_q & ~irq_mask);
endmodule

// File: rtl/spi_rqc_chk.sv
module spi_rqc_chk #(
  parameter  int DEPTH = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input logic        clk,
  input logic        rst_s,
  input logic [2:0]  state_q,
  input logic        cs_fall,
  input logic        cs_rise,
  input logic [1:0]  sts_q,
  input logic [AW:0] level,
  input logic        hold_full,
  input logic        auto_flush,
  input logic        pop,
  input logic        cpu_en
);
  localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

  p_state_legal_r4: assert property (@(posedge clk) disable iff (!rst_s)
    state_q <= 3'd4);

  p_csfall_busy_r3: assert property (@(posedge clk) disable iff (!rst_s)
    (cs_fall && state_q != 3'd0) |=> (state_q == 3'd3));

  p_end_flag_r6: assert property (@(posedge clk) disable iff (!rst_s)
    (cs_rise && state_q != 3'd0) |=> (sts_q[1] && state_q == 3'd1));

  p_level_bound_r10: assert property (@(posedge clk) disable iff (!rst_s)
    level <= FULL_LVL);

  p_hold_full_r10: assert property (@(posedge clk) disable iff (!rst_s)
    (level == FULL_LVL && hold_full && !(pop && cpu_en) && !(cs_rise && auto_flush))
      |=> (level == FULL_LVL));
endmodule

bind spi_rqc_top spi_rqc_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_s(rst_s), .state_q(state_q), .cs_fall(cs_fall),
  .cs_rise(cs_rise), .sts_q(sts_q), .level(rx_level),
  .hold_full(cfg_hold_full), .auto_flush(cfg_auto_flush), .pop(rx_pop),
  .cpu_en(cpu_rx_en)
);

// File: tb/tb_spi_rqc_top.sv
module tb_spi_rqc_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        spi_sclk, spi_mosi, spi_cs_n;
  logic        spi_miso;
  logic [15:0] cfg_base_cnt, cfg_len_off;
  logic        cfg_auto_flush, cfg_hold_full;
  logic [1:0]  irq_mask;
  logic        state_we;
  logic [2:0]  state_wdata;
  logic        sts_clr_we;
  logic [1:0]  sts_clr;
  logic        cpu_rx_en, rx_pop;
  logic [31:0] rx_data;
  logic        rx_valid;
  logic [3:0]  rx_level;
  logic [1:0]  sts;
  logic [2:0]  state_o;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  spi_rqc_top dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  localparam int HP = 8;

  task automatic cs_low();
    spi_cs_n = 1'b0; wclk(HP);
  endtask

  task automatic cs_high();
    spi_cs_n = 1'b1; wclk(HP);
  endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      spi_mosi = b[i];
      wclk(HP);
      r[i] = spi_miso;
      spi_sclk = 1'b1;
      wclk(HP);
      spi_sclk = 1'b0;
    end
    wclk(2);
  endtask

  task automatic set_state(input logic [2:0] v);
    state_wdata = v; state_we = 1'b1; wclk(1); state_we = 1'b0; wclk(1);
  endtask

  task automatic clear_sts(input logic [1:0] m);
    sts_clr = m; sts_clr_we = 1'b1; wclk(1); sts_clr_we = 1'b0; wclk(1);
  endtask

  task automatic pop_word();
    rx_pop = 1'b1; wclk(1); rx_pop = 1'b0; wclk(1);
  endtask

  task automatic send_incr(input int n);
    logic [7:0] r;
    cs_low();
    for (int i = 0; i < n; i++) xfer(8'(i), r);
    cs_high();
  endtask

  task automatic t_reset();
    check("R1 state", 32'(state_o), 0);
    check("R1 sts", 32'(sts), 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 miso", 32'(spi_miso), 0);
    check("R1 level", 32'(rx_level), 0);
  endtask

  task automatic t_disabled();
    logic [7:0] r;
    cs_low();
    check("R3 disabled stays off", 32'(state_o), 0);
    xfer(8'h55, r);
    check("R2 disabled code", 32'(r), 32'hEC);
    cs_high();
    check("R6 disabled no end flag", 32'(sts), 0);
    check("R6 disabled state", 32'(state_o), 0);
  endtask

  task automatic t_state_write();
    set_state(3'd1);
    check("R4 load ready", 32'(state_o), 1);
    set_state(3'd6);
    check("R4 illegal ignored", 32'(state_o), 1);
  endtask

  task automatic t_capture();
    logic [7:0] r;
    logic [7:0] hdr [4];
    hdr[0] = 8'h03; hdr[1] = 8'h00; hdr[2] = 8'h05; hdr[3] = 8'h00;
    cfg_base_cnt = 16'd8; cfg_len_off = 16'd2; irq_mask = 2'b10;
    cs_low();
    check("R3 busy after select", 32'(state_o), 3);
    for (int i = 0; i < 16; i++) begin
      xfer((i < 4) ? hdr[i] : 8'(i), r);
      if (i == 0)  check("R2 first byte busy", 32'(r), 32'hFA);
      if (i == 15) check("R2 last byte busy", 32'(r), 32'hFA);
      if (i == 11) check("R5 not yet at 12 bytes", 32'(sts[0]), 0);
      if (i == 12) check("R5 set at 13 bytes", 32'(sts[0]), 1);
      if (i == 12) check("R8 irq from valid-length", 32'(irq), 1);
    end
    cs_high();
    check("R6 end flag", 32'(sts), 3);
    check("R6 ready after release", 32'(state_o), 1);
  endtask

  task automatic t_end_clear();
    clear_sts(2'b01);
    check("R7 clear bit0 only", 32'(sts), 2);
    check("R8 end masked", 32'(irq), 0);
    irq_mask = 2'b00; wclk(1);
    check("R8 end unmasked", 32'(irq), 1);
    clear_sts(2'b10);
    check("R7 clear bit1", 32'(sts), 0);
    check("R8 irq low", 32'(irq), 0);
  endtask

  task automatic t_read();
    logic [31:0] exp [4];
    exp[0] = 32'h00050003; exp[1] = 32'h07060504;
    exp[2] = 32'h0B0A0908; exp[3] = 32'h0F0E0D0C;
    check("R9 level", 32'(rx_level), 4);
    check("R9 no valid without access", 32'(rx_valid), 0);
    cpu_rx_en = 1'b1; wclk(1);
    for (int i = 0; i < 4; i++) begin
      check("R9 packed word", rx_data, exp[i]);
      pop_word();
    end
    check("R9 empty after reads", 32'(rx_valid), 0);
    cpu_rx_en = 1'b0; wclk(1);
  endtask

  task automatic t_flush();
    cfg_auto_flush = 1'b1;
    send_incr(8);
    check("R12 flushed on release", 32'(rx_level), 0);
    cfg_auto_flush = 1'b0;
  endtask

  task automatic t_hold();
    cfg_hold_full = 1'b1;
    send_incr(40);
    check("R10 level full", 32'(rx_level), 8);
    cpu_rx_en = 1'b1; wclk(1);
    check("R10 oldest kept", rx_data, 32'h03020100);
    for (int i = 0; i < 8; i++) pop_word();
    cpu_rx_en = 1'b0; wclk(1);
  endtask

  task automatic t_overwrite();
    cfg_hold_full = 1'b0;
    send_incr(40);
    check("R11 level full", 32'(rx_level), 8);
    cpu_rx_en = 1'b1; wclk(1);
    check("R11 oldest replaced", rx_data, 32'h0B0A0908);
    for (int i = 0; i < 8; i++) pop_word();
    check("R11 drained", 32'(rx_level), 0);
  endtask

  task automatic t_cpu_block();
    send_incr(8);
    check("R13 nothing stored under access", 32'(rx_level), 0);
    cpu_rx_en = 1'b0; wclk(1);
  endtask

  task automatic t_codes();
    logic [7:0] r;
    cfg_auto_flush = 1'b1;
    cs_low();
    set_state(3'd2); xfer(8'h00, r); xfer(8'h00, r);
    check("R2 receiving code", 32'(r), 32'hF9);
    set_state(3'd1); xfer(8'h00, r); xfer(8'h00, r);
    check("R2 ready code", 32'(r), 32'hF8);
    set_state(3'd4); xfer(8'h00, r); xfer(8'h00, r);
    check("R2 bad data code", 32'(r), 32'hFB);
    cs_high();
    check("R2 miso idle", 32'(spi_miso), 0);
  endtask

  initial begin
    rst_n = 1'b0; spi_sclk = 1'b0; spi_mosi = 1'b0; spi_cs_n = 1'b1;
    cfg_base_cnt = 16'd8; cfg_len_off = 16'd2; cfg_auto_flush = 1'b0;
    cfg_hold_full = 1'b1; irq_mask = 2'b00; state_we = 1'b0;
    state_wdata = 3'd0; sts_clr_we = 1'b0; sts_clr = 2'b00;
    cpu_rx_en = 1'b0; rx_pop = 1'b0;
    wclk(3); rst_n = 1'b1; wclk(4);
    t_reset();
    t_disabled();
    t_state_write();
    t_capture();
    t_end_clear();
    t_read();
    t_flush();
    t_hold();
    t_overwrite();
    t_cpu_block();
    t_codes();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule